// File: doc/BRIEF.md
# Multichannel Serial ADC Conversion Sequencer

This block is the host side of a link to an external 8-input, 12-bit successive-approximation converter with a synchronous serial port. It divides the system clock down to a serial data clock and controls chip select. For every conversion it sends a command byte that carries the channel address, the input mode and the power setting. It then reads back the 12-bit result. The channels come from a programmable list of up to eight entries. The sequencer walks that list in order and goes back to the first entry after the last enabled one.

A frame can be 24, 16 or 15 data clocks long, chosen per conversion by a mode input. In the two shorter frames, the command byte for the next conversion goes out while the low-order bits of the current result are still arriving. The capture logic therefore runs on its own counter, separate from the frame counter. Each finished result is tagged with the channel it came from and is offered on a valid/ready stream. When the consumer holds back, the sequencer does not start another conversion. It lets any read already in flight finish and then parks with chip select high.

Top module: `adc_seq`

## Requirements
- R1: While reset is held and right after it is released, chip select is high, the data clock is low, the serial command line is low and no result is valid.
- R2: Each command byte is sent MSB first and is latched by the converter on data clock rising edges. Bit 7 is a 1 (start marker). Bits 6..4 are the address, formed from the entry's channel number c as {c[0], c[2], c[1]}. Bit 3 is 0. Bit 2 is the single-ended select (1) or differential select (0). Bits 1..0 are the power setting. Outside these eight bits the command line is 0.
- R3: While chip select is low, the data clock is a square wave whose period is 2*DIV system clocks. The data clock never rises while chip select is high.
- R4: In back-to-back operation, consecutive start markers are 24 data clocks apart for mode code 0 or 3, 16 apart for code 1 and 15 apart for code 2. The code is taken when each conversion starts.
- R5: The 12 result bits are sampled MSB first on the rising edges of data clocks 10 through 21, counted from the conversion's start marker on clock 1. They are delivered unchanged as a straight binary code (0 up to 4095).
- R6: Every delivered result carries, on res_chan, the channel number of the list entry that produced it.
- R7: Conversions use list entries 0, 1, … up to last_idx and then wrap to entry 0. When run is low and the block is idle, the next run starts again at entry 0.
- R8: A conversion starts only if the output holds no result and no finished capture is waiting. If the output is stalled, a read already in flight is completed, chip select goes high, and no result is lost.
- R9: While res_valid is high and res_ready is low, res_valid stays high and res_data and res_chan do not change.
- R10: When run drops, the conversion in progress completes and its result is delivered. After that, no further start marker is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables continuous sequencing |
| mode | input | 2 | Frame length code: 0/3 = 24, 1 = 16, 2 = 15 data clocks |
| chan_list | input | 3*LIST_N | Channel number of each list entry, entry i in bits [3i+2:3i] |
| last_idx | input | clog2(LIST_N) | Index of the last enabled list entry |
| single_end | input | 1 | 1 = single-ended input, 0 = differential pair |
| pwr | input | 2 | Power setting copied into the command byte |
| sclk | output | 1 | Serial data clock to the converter |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial command line |
| miso | input | 1 | Serial result line from the converter |
| res_valid | output | 1 | Result available |
| res_data | output | RW | Conversion result, straight binary |
| res_chan | output | 3 | Channel that produced the result |
| res_ready | input | 1 | Consumer accepts the result |

## Verification
The hardest case to reach is an overlapped frame mode with the consumer stalled. In that case a second conversion is already in flight when the first result is stuck in the output, and the second result must be held internally while the data clock drains out of the frame. The bench gets there by holding ready low before run rises in the 16- and 15-clock modes. It lets exactly two start markers through, waits long enough for the drain to finish, and then checks three things: chip select is high, no third marker was sent, and the output stayed frozen. When ready is released, both results must come out in order. A behavioural converter model decodes every command byte and sends back a per-channel code chosen to include 0, 4095 and alternating bit patterns. The frame spacing in each mode is measured from the gaps between start markers.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int DIV    = 2,
  parameter int LIST_N = 8,
  parameter int RW     = 12,
  localparam int IW    = (LIST_N > 1) ? $clog2(LIST_N) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic [1:0]            mode,
  input  logic [3*LIST_N-1:0]   chan_list,
  input  logic [IW-1:0]         last_idx,
  input  logic                  single_end,
  input  logic [1:0]            pwr,
  output logic                  sclk,
  output logic                  cs_n,
  output logic                  mosi,
  input  logic                  miso,
  output logic                  res_valid,
  output logic [RW-1:0]         res_data,
  output logic [2:0]            res_chan,
  input  logic                  res_ready
);
  localparam int DW    = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int CBW   = $clog2(RW + 1);
  localparam int CAP_K = 9;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} st_t;
  st_t st;

  logic [DW-1:0]  div_cnt;
  logic [4:0]     k, flen, mode_len;
  logic [IW-1:0]  ptr;
  logic [6:0]     tx;
  logic [2:0]     cur_ch, cap_ch, nxt_ch;
  logic [7:0]     ctl_byte;
  logic           cap_on, cap_full;
  logic [CBW-1:0] cbit;
  logic [RW-1:0]  cap_sh;
  logic           tick, rise, fall, can_start;

  assign nxt_ch    = chan_list[3*32'(ptr) +: 3];
  assign ctl_byte  = {1'b1, nxt_ch[0], nxt_ch[2:1], 1'b0, single_end, pwr};
  assign mode_len  = (mode == 2'd1) ? 5'd16 : (mode == 2'd2) ? 5'd15 : 5'd24;
  assign tick      = (st != ST_IDLE) && (div_cnt == DW'(DIV - 1));
  assign rise      = tick && !sclk;
  assign fall      = tick && sclk;
  assign can_start = run && !res_valid && !cap_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      sclk    <= 1'b0;
      cs_n    <= 1'b1;
      mosi    <= 1'b0;
      div_cnt <= '0;
      k       <= '0;
      flen    <= 5'd24;
      ptr     <= '0;
      tx      <= '0;
      cur_ch  <= '0;
    end else if (st == ST_IDLE) begin
      div_cnt <= '0;
      if (!run) ptr <= '0;
      else if (can_start) begin
        cs_n   <= 1'b0;
        st     <= ST_RUN;
        tx     <= ctl_byte[6:0];
        mosi   <= ctl_byte[7];
        cur_ch <= nxt_ch;
        ptr    <= (ptr == last_idx) ? '0 : ptr + 1'b1;
        k      <= '0;
        flen   <= mode_len;
      end
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (rise) begin
        sclk <= 1'b1;
        if (st == ST_RUN) k <= k + 1'b1;
      end
      if (fall) begin
        sclk <= 1'b0;
        if (st == ST_DRAIN) begin
          if (!cap_on) begin
            st   <= ST_IDLE;
            cs_n <= 1'b1;
          end
        end else if (k == flen) begin
          if (can_start) begin
            tx     <= ctl_byte[6:0];
            mosi   <= ctl_byte[7];
            cur_ch <= nxt_ch;
            ptr    <= (ptr == last_idx) ? '0 : ptr + 1'b1;
            k      <= '0;
            flen   <= mode_len;
          end else if (cap_on) begin
            st   <= ST_DRAIN;
            mosi <= 1'b0;
          end else begin
            st   <= ST_IDLE;
            cs_n <= 1'b1;
            mosi <= 1'b0;
          end
        end else begin
          mosi <= tx[6];
          tx   <= {tx[5:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_on    <= 1'b0;
      cap_full  <= 1'b0;
      cbit      <= '0;
      cap_sh    <= '0;
      cap_ch    <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_chan  <= '0;
    end else begin
      if (res_valid && res_ready) res_valid <= 1'b0;
      if (cap_full && (!res_valid || res_ready)) begin
        res_valid <= 1'b1;
        res_data  <= cap_sh;
        res_chan  <= cap_ch;
        cap_full  <= 1'b0;
      end
      if (rise) begin
        if (st == ST_RUN && k == 5'(CAP_K)) begin
          cap_on <= 1'b1;
          cbit   <= CBW'(1);
          cap_sh <= {{(RW-1){1'b0}}, miso};
          cap_ch <= cur_ch;
        end else if (cap_on) begin
          cap_sh <= {cap_sh[RW-2:0], miso};
          cbit   <= cbit + 1'b1;
          if (cbit == CBW'(RW - 1)) begin
            cap_on   <= 1'b0;
            cap_full <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int RW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sclk,
  input logic          cs_n,
  input logic          mosi,
  input logic          res_valid,
  input logic          res_ready,
  input logic [RW-1:0] res_data,
  input logic [2:0]    res_chan
);
  p_clk_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> !cs_n);

  p_idle_clk_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_cmd_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !mosi);

  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_chan)));

  p_start_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !$past(res_valid));
endmodule

bind adc_seq adc_seq_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data), .res_chan(res_chan)
);

// File: tb/adc_seq_bench.sv
`timescale 1ns/1ps
module adc_seq_bench;
  localparam int DIV = 2;
  localparam int LN  = 8;
  localparam int RW  = 12;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, se = 1'b1, rdy = 1'b1;
  logic [1:0] mode = 2'd0, pd = 2'b11;
  logic [3*LN-1:0] clist;
  logic [2:0] last = 3'd7;
  logic sclk, cs_n, mosi, miso, res_valid;
  logic [RW-1:0] res_data;
  logic [2:0] res_chan;

  always #2.5 clk = ~clk;

  adc_seq #(.DIV(DIV), .LIST_N(LN), .RW(RW)) u_adc_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .chan_list(clist),
    .last_idx(last), .single_end(se), .pwr(pd), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .res_valid(res_valid), .res_data(res_data),
    .res_chan(res_chan), .res_ready(rdy)
  );

  int nchk = 0, nbad = 0;
  task automatic check(input string tag, input logic ok, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  logic [2:0]  lst  [8] = '{3'd5, 3'd2, 3'd7, 3'd0, 3'd6, 3'd1, 3'd4, 3'd3};
  logic [11:0] vals [8] = '{12'h000, 12'hFFF, 12'h800, 12'h7FF, 12'hA5A, 12'h5A5, 12'h001, 12'hFFE};
  logic [14:0] exp_q[$];
  logic [7:0]  byte_q[$];
  int expP = 24;

  // behavioural converter
  int rx_cnt = 0, out_cnt = 99, rises_since = 0, dev_starts = 0, cyc = 0, cyc_rise = 0;
  logic [7:0]  rx_byte = 8'h00, eb;
  logic [11:0] dev_res = 12'h000;
  logic [2:0]  a;
  logic dev_dout = 1'b0, gap_on = 1'b0, rise_ok = 1'b0;
  assign miso = dev_dout;

  always @(posedge clk) cyc++;

  always @(posedge cs_n) begin
    dev_dout = 1'b0; rx_cnt = 0; out_cnt = 99; gap_on = 1'b0; rise_ok = 1'b0;
  end

  always @(posedge sclk) if (!cs_n) begin
    if (rise_ok) check("R3 data clock period", (cyc - cyc_rise) == 2*DIV, cyc - cyc_rise, 2*DIV);
    cyc_rise = cyc; rise_ok = 1'b1;
    rises_since++;
    if (out_cnt < 99) out_cnt++;
    if (rx_cnt == 0) begin
      if (mosi) begin
        if (gap_on) check("R4 frame length", rises_since == expP, rises_since, expP);
        gap_on = 1'b1; rises_since = 0;
        rx_cnt = 1; rx_byte = 8'h01; dev_starts++;
      end
    end else begin
      rx_byte = {rx_byte[6:0], mosi};
      rx_cnt++;
      if (rx_cnt == 8) begin
        rx_cnt = 0;
        if (byte_q.size() == 0) check("R2 R10 unexpected command byte", 1'b0, int'(rx_byte), 0);
        else begin
          eb = byte_q.pop_front();
          check("R2 command byte", rx_byte == eb, int'(rx_byte), int'(eb));
        end
        a = rx_byte[6:4];
        dev_res = vals[{a[1:0], a[2]}];
        out_cnt = 8;
      end
    end
  end

  always @(negedge sclk) if (!cs_n)
    dev_dout = (out_cnt >= 9 && out_cnt <= 20) ? dev_res[20 - out_cnt] : 1'b0;

  // scoreboard monitor
  logic [14:0] e;
  always @(negedge clk) if (rst_n && res_valid && rdy) begin
    if (exp_q.size() == 0) check("R6 unexpected result", 1'b0, int'(res_data), 0);
    else begin
      e = exp_q.pop_front();
      check("R5 result code", res_data == e[11:0], int'(res_data), int'(e[11:0]));
      check("R6 R7 channel tag and order", res_chan == e[14:12], int'(res_chan), int'(e[14:12]));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic load_exp(input int n, input int lastx, input logic sex, input logic [1:0] pdx);
    logic [2:0] c;
    for (int i = 0; i < n; i++) begin
      c = lst[i % (lastx + 1)];
      byte_q.push_back({1'b1, c[0], c[2:1], 1'b0, sex, pdx});
      exp_q.push_back({c, vals[c]});
    end
  endtask

  task automatic batch(input int md, input int n, input int lastx, input logic sex, input logic [1:0] pdx);
    int s0;
    mode = 2'(md); last = 3'(lastx); se = sex; pd = pdx;
    expP = (md == 1) ? 16 : (md == 2) ? 15 : 24;
    load_exp(n, lastx, sex, pdx);
    s0 = dev_starts;
    run = 1'b1;
    wait (dev_starts == s0 + n);
    step(1);
    run = 1'b0;
    wait (exp_q.size() == 0 && cs_n);
    step(40);
    check("R10 no start after run drops", dev_starts == s0 + n, dev_starts - s0, n);
    check("R2 all command bytes seen", byte_q.size() == 0, byte_q.size(), 0);
  endtask

  task automatic stall(input int md);
    int s0, n;
    logic [RW-1:0] d0;
    n = (md == 0) ? 1 : 2;
    mode = 2'(md); last = 3'd7; se = 1'b1; pd = 2'b00;
    expP = (md == 1) ? 16 : (md == 2) ? 15 : 24;
    load_exp(n, 7, 1'b1, 2'b00);
    rdy = 1'b0;
    s0 = dev_starts;
    run = 1'b1;
    wait (dev_starts == s0 + n);
    step(400);
    check("R8 chip select high while stalled", cs_n == 1'b1, int'(cs_n), 1);
    check("R8 no further conversion while stalled", dev_starts == s0 + n, dev_starts - s0, n);
    check("R9 valid held while stalled", res_valid == 1'b1, int'(res_valid), 1);
    d0 = res_data;
    step(50);
    check("R9 data stable while stalled", res_data == d0, int'(res_data), int'(d0));
    run = 1'b0;
    step(1);
    rdy = 1'b1;
    wait (exp_q.size() == 0 && cs_n);
    step(40);
    check("R8 no result lost", exp_q.size() == 0, exp_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < LN; i++) clist[3*i +: 3] = lst[i];
    step(5);
    check("R1 chip select in reset", cs_n == 1'b1, int'(cs_n), 1);
    check("R1 data clock in reset", sclk == 1'b0, int'(sclk), 0);
    rst_n = 1'b1;
    step(3);
    check("R1 chip select after reset", cs_n == 1'b1, int'(cs_n), 1);
    check("R1 no result after reset", res_valid == 1'b0, int'(res_valid), 0);
    check("R1 command line low", mosi == 1'b0, int'(mosi), 0);
    batch(0, 8, 7, 1'b1, 2'b11);
    batch(1, 7, 2, 1'b0, 2'b00);
    batch(2, 10, 7, 1'b1, 2'b00);
    batch(3, 3, 0, 1'b0, 2'b11);
    batch(2, 5, 3, 1'b0, 2'b11);
    stall(1);
    stall(2);
    stall(0);
    finish_run();
  end
endmodule